// File: doc/BRIEF.md
# Balanced Ternary Multiplexer Function Unit

This block evaluates a single-argument function on one balanced-ternary digit (a trit, holding -1, 0 or +1). At its core is a three-way multiplexer whose selector is itself a trit. A selector of -1 passes the negative-side data trit to the output, 0 passes the middle data trit, and +1 passes the positive-side data trit.

A small decoder turns a static opcode into three constant trits, one for each data input of the multiplexer. The argument trit drives the selector, so the output is whichever constant sits in the slot the argument picks. With this one structure the block provides identity, cyclic increment, cyclic decrement, max(A,0) and min(A,0).

The unit is purely combinational. Each trit travels on two wires.

Top module: `tern_fn_unit`

## Requirements
- R1: Trits use a two-bit code: 2'b11 is -1, 2'b00 is 0, 2'b01 is +1, and 2'b10 is illegal.
- R2: Opcode 0 (identity) returns the argument unchanged.
- R3: Opcode 1 (increment) maps -1 to 0 and 0 to +1, and wraps +1 around to -1.
- R4: Opcode 2 (decrement) maps +1 to 0 and 0 to -1, and wraps -1 around to +1.
- R5: Opcode 3 returns max(A,0), which is 0 when A is -1 and A in every other case.
- R6: Opcode 4 returns min(A,0), which is A when A is -1 and 0 in every other case.
- R7: Opcodes 5, 6 and 7 behave exactly as identity.
- R8: An argument carrying the illegal code 2'b10 forces the result to 0 and raises selErr, whatever the opcode.
- R9: selErr stays low whenever the argument carries a legal code.
- R10: The result never carries the illegal code 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 3 | Function select (0 identity, 1 increment, 2 decrement, 3 max with 0, 4 min with 0, others identity) |
| argIn | input | 2 | Argument trit; acts as the multiplexer selector |
| result | output | 2 | Function result trit |
| selErr | output | 1 | High when argIn holds the illegal code |

## Verification
The assertions assume that the opcode and the argument are never X or Z and are steady whenever they are checked. They also assume that the argument may take any of its four codes, including the illegal one, and that any opcode value can appear.

The stimulus respects these assumptions. The bench changes its inputs only just after a rising clock edge and samples the outputs at the falling edge, so the combinational path has settled by the time anything is checked. It drives the whole eight-by-four space of opcodes and argument codes on purpose, so the illegal selector code and the opcodes with no function of their own are both covered.

// File: rtl/tern_pkg.sv
`timescale 1ns/1ps
package tern_pkg;
  localparam int TRIT_W = 2;
  localparam int OP_W   = 3;

  typedef logic [TRIT_W-1:0] trit_t;

  localparam trit_t T_NEG  = 2'b11;
  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_POS  = 2'b01;
  localparam trit_t T_BAD  = 2'b10;

  localparam int OPC_IDENT = 0;
  localparam int OPC_INC   = 1;
  localparam int OPC_DEC   = 2;
  localparam int OPC_MAX   = 3;
  localparam int OPC_MIN   = 4;

  // constants tied to the three data inputs of the multiplexer
  typedef struct packed {
    trit_t negIn;
    trit_t zeroIn;
    trit_t posIn;
  } mux_wiring_t;
endpackage

// File: rtl/tern_fn_ctrl.sv
`timescale 1ns/1ps
module tern_fn_ctrl
  import tern_pkg::*;
#(
  parameter int OP_WIDTH = OP_W
) (
  input  logic [OP_WIDTH-1:0] opCode,
  output mux_wiring_t         wiring
);
  // each function is a column of three constants read out by the argument
  always_comb begin
    wiring = '{negIn: T_NEG, zeroIn: T_ZERO, posIn: T_POS};
    if (opCode == OP_WIDTH'(OPC_INC))
      wiring = '{negIn: T_ZERO, zeroIn: T_POS, posIn: T_NEG};
    else if (opCode == OP_WIDTH'(OPC_DEC))
      wiring = '{negIn: T_POS, zeroIn: T_NEG, posIn: T_ZERO};
    else if (opCode == OP_WIDTH'(OPC_MAX))
      wiring = '{negIn: T_ZERO, zeroIn: T_ZERO, posIn: T_POS};
    else if (opCode == OP_WIDTH'(OPC_MIN))
      wiring = '{negIn: T_NEG, zeroIn: T_ZERO, posIn: T_ZERO};
  end
endmodule

// File: rtl/tern_mux.sv
`timescale 1ns/1ps
module tern_mux
  import tern_pkg::*;
(
  input  trit_t       selTrit,
  input  mux_wiring_t wiring,
  output trit_t       outTrit,
  output logic        selBad
);
  always_comb begin
    selBad  = 1'b0;
    outTrit = T_ZERO;
    case (selTrit)
      T_NEG:   outTrit = wiring.negIn;
      T_ZERO:  outTrit = wiring.zeroIn;
      T_POS:   outTrit = wiring.posIn;
      default: selBad  = 1'b1;
    endcase
  end
endmodule

// File: rtl/tern_fn_unit.sv
`timescale 1ns/1ps
module tern_fn_unit
  import tern_pkg::*;
#(
  parameter int OP_WIDTH = OP_W
) (
  input  logic [OP_WIDTH-1:0] opCode,
  input  logic [TRIT_W-1:0]   argIn,
  output logic [TRIT_W-1:0]   result,
  output logic                selErr
);
  mux_wiring_t wiring;

  tern_fn_ctrl #(.OP_WIDTH(OP_WIDTH)) u_ctrl (
    .opCode (opCode),
    .wiring (wiring)
  );

  tern_mux u_mux (
    .selTrit (argIn),
    .wiring  (wiring),
    .outTrit (result),
    .selBad  (selErr)
  );
endmodule

// File: rtl/tern_fn_unit_chk.sv
`timescale 1ns/1ps
module tern_fn_unit_chk
  import tern_pkg::*;
#(
  parameter int OP_WIDTH = OP_W
) (
  input logic [OP_WIDTH-1:0] opCode,
  input logic [TRIT_W-1:0]   argIn,
  input logic [TRIT_W-1:0]   result,
  input logic                selErr
);
  always_comb begin
    p_never_bad_code_r10: assert (result != T_BAD)
      else $error("result carries illegal code");
    p_err_forces_zero_r8: assert (!selErr || result == T_ZERO)
      else $error("selErr with nonzero result");
    p_err_tracks_sel_r9: assert (selErr == (argIn == T_BAD))
      else $error("selErr disagrees with argument code");
    p_inc_wraps_r3: assert (!(opCode == OP_WIDTH'(OPC_INC) && argIn == T_POS) || result == T_NEG)
      else $error("increment of +1 did not wrap");
    p_dec_wraps_r4: assert (!(opCode == OP_WIDTH'(OPC_DEC) && argIn == T_NEG) || result == T_POS)
      else $error("decrement of -1 did not wrap");
    p_max_nonneg_r5: assert (!(opCode == OP_WIDTH'(OPC_MAX)) || result != T_NEG)
      else $error("max with 0 went negative");
    p_min_nonpos_r6: assert (!(opCode == OP_WIDTH'(OPC_MIN)) || result != T_POS)
      else $error("min with 0 went positive");
  end
endmodule

bind tern_fn_unit tern_fn_unit_chk #(.OP_WIDTH(OP_WIDTH)) u_chk (
  .opCode (opCode),
  .argIn  (argIn),
  .result (result),
  .selErr (selErr)
);

// File: tb/tb_tern_fn_unit.sv
`timescale 1ns/1ps
module tb_tern_fn_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opCode = '0;
  logic [1:0] argIn = '0;
  logic [1:0] result;
  logic       selErr;
  int         nChecks = 0;
  int         nFails = 0;

  always #4 clk = ~clk;

  tern_fn_unit dut (
    .opCode (opCode),
    .argIn  (argIn),
    .result (result),
    .selErr (selErr)
  );

  // {opcode, argument, expected result, expected selErr}
  localparam logic [7:0] VEC [17] = '{
    {3'd0, 2'b11, 2'b11, 1'b0}, {3'd0, 2'b00, 2'b00, 1'b0}, {3'd0, 2'b01, 2'b01, 1'b0},
    {3'd1, 2'b11, 2'b00, 1'b0}, {3'd1, 2'b00, 2'b01, 1'b0}, {3'd1, 2'b01, 2'b11, 1'b0},
    {3'd2, 2'b11, 2'b01, 1'b0}, {3'd2, 2'b00, 2'b11, 1'b0}, {3'd2, 2'b01, 2'b00, 1'b0},
    {3'd3, 2'b11, 2'b00, 1'b0}, {3'd3, 2'b00, 2'b00, 1'b0}, {3'd3, 2'b01, 2'b01, 1'b0},
    {3'd4, 2'b11, 2'b11, 1'b0}, {3'd4, 2'b00, 2'b00, 1'b0}, {3'd4, 2'b01, 2'b00, 1'b0},
    {3'd5, 2'b01, 2'b01, 1'b0}, {3'd7, 2'b11, 2'b11, 1'b0}
  };

  task automatic check(input string req, input logic [1:0] expRes, input logic expErr);
    nChecks++;
    if (result !== expRes || selErr !== expErr) begin
      nFails++;
      $display("FAIL %s op=%0d arg=%b: got result=%b selErr=%b, expected result=%b selErr=%b",
               req, opCode, argIn, result, selErr, expRes, expErr);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [1:0] arg);
    @(posedge clk);
    opCode = op;
    argIn  = arg;
    @(negedge clk);
  endtask

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: opcode 0 and argument 0 (code 2'b00 is zero, R1)
    @(negedge clk);
    check("R1", 2'b00, 1'b0);

    for (int i = 0; i < 17; i++) begin
      apply(VEC[i][7:5], VEC[i][4:3]);
      check(reqOf(VEC[i][7:5]), VEC[i][2:1], VEC[i][0]);
    end

    // opcodes without a function of their own mirror the argument (R7)
    for (int op = 5; op < 8; op++) begin
      for (int a = 0; a < 4; a++) begin
        if (a != 2) begin
          apply(3'(op), 2'(a));
          check("R7", 2'(a), 1'b0);
        end
      end
    end

    // illegal selector code under every opcode (R8)
    for (int op = 0; op < 8; op++) begin
      apply(3'(op), 2'b10);
      check("R8", 2'b00, 1'b1);
    end

    // full sweep: no illegal result code (R10), no error on legal codes (R9)
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 4; a++) begin
        apply(3'(op), 2'(a));
        nChecks++;
        if (result === 2'b10 || selErr !== (a == 2)) begin
          nFails++;
          $display("FAIL R9/R10 op=%0d arg=%0d: got result=%b selErr=%b, expected legal result and selErr=%b",
                   op, a, result, selErr, (a == 2));
        end
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule